// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Emulator

This block recreates the three interrupt sources of a classic real-time clock (seconds update, time-of-day alarm and periodic rate) on top of a free-running timestamp counter. An internal compare point is armed whenever at least one source is enabled. Each time the timestamp reaches that point, the block takes one poll. At each poll it compares the current seconds against the last recorded value. It also matches hours, minutes and seconds against the alarm setting and advances a periodic divider. If any of these raises a flag, it emits a one-cycle interrupt strobe together with a packed status word.

Slow periodic rates (at or below the base polling rate) are produced by dividing base polls by `limit_i`. Faster rates are produced by setting `limit_i` to zero, which switches the poll interval to `fast_delta_i` so that every poll raises the periodic flag. If the timestamp has run past more than one interval by the time a poll is serviced, the compare point is stepped forward one interval per cycle until it is ahead again. Every extra step is a missed poll. Missed polls are added to the periodic divider and to a saturating running total.

Top module: `rtc_emu`

## Requirements
- R1: After reset `irq_o` is 0, `status_o` is 0 and `missed_o` is 0.
- R2: While `uie_i`, `aie_i` and `pie_i` are all 0 the compare channel is disarmed and no interrupt is produced, whatever the time inputs do.
- R3: The first poll after `uie_i` goes from 0 to 1 only records `sec_i` and raises no update flag, even if the seconds differ from a value recorded during an earlier enable period.
- R4: With `uie_i` set, a poll raises the update flag (status bit 4) only when `sec_i` differs from the seconds recorded at the previous poll; the new value is then recorded.
- R5: With `aie_i` set, a poll raises the alarm flag (status bit 5) only when hours, minutes and seconds all equal the alarm fields; a mismatch in any one field raises nothing.
- R6: With `pie_i` set and `limit_i` = L > 0, the periodic flag (status bit 6) is raised on every L-th poll. Polls are spaced `base_delta_i` timestamp units apart, so flags come L*`base_delta_i` apart.
- R7: With `pie_i` set and `limit_i` = 0, the poll interval becomes `fast_delta_i` and every poll raises the periodic flag.
- R8: Whenever any flag is raised, `irq_o` pulses for exactly one cycle. In the same cycle `status_o` carries the flags, bit 7 set as interrupt-pending and the value 1 in bits 15:8. `status_o` is 0 whenever `irq_o` is 0.
- R9: When a poll is serviced late by k whole intervals, k is added to `missed_o` (saturating) and to the periodic divider. The next periodic flag therefore comes k polls earlier. Intervals must be at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| now_i | input | CW | Free-running timestamp |
| base_delta_i | input | CW | Poll interval for base rate |
| fast_delta_i | input | CW | Poll interval when periodic limit is 0 |
| uie_i | input | 1 | Update interrupt enable |
| aie_i | input | 1 | Alarm interrupt enable |
| pie_i | input | 1 | Periodic interrupt enable |
| sec_i | input | 6 | Current seconds |
| min_i | input | 6 | Current minutes |
| hr_i | input | 5 | Current hours |
| alm_sec_i | input | 6 | Alarm seconds |
| alm_min_i | input | 6 | Alarm minutes |
| alm_hr_i | input | 5 | Alarm hours |
| limit_i | input | LIM_W | Periodic divider limit, 0 selects fast interval |
| irq_o | output | 1 | One-cycle interrupt strobe |
| status_o | output | 16 | Flags, pending bit and interrupt count |
| missed_o | output | MISS_W | Running total of missed polls |

## Verification
The bench targets the stale-seconds case: re-enabling the update source after the seconds have moved must stay silent. A design that kept the old recorded value would raise a spurious update flag. Partial alarm matches check that a block comparing too few fields would fire early. Exact strobe spacing in the slow and fast periodic modes exposes an off-by-one divider or a wrong interval selection. A forward jump of the timestamp by five intervals must yield exactly four missed polls and an early periodic flag. A design that dropped, or double-counted, the catch-up steps would show a different total or flag timing.

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;
  localparam int STW       = 16;
  localparam int FLAG_UF   = 4;
  localparam int FLAG_AF   = 5;
  localparam int FLAG_PF   = 6;
  localparam int FLAG_PEND = 7;
  localparam int CNT_LSB   = 8;

  typedef enum logic [1:0] {S_OFF, S_RUN, S_CATCH} sched_st_e;

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } tod_t;
endpackage

// File: rtl/rtc_emu_sched.sv
module rtc_emu_sched
  import rtc_emu_pkg::*;
#(
  parameter int CW     = 32,
  parameter int LOST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [CW-1:0]     now_i,
  input  logic [CW-1:0]     delta_i,
  output logic              fire_o,
  output logic [LOST_W-1:0] lost_o
);
  sched_st_e         st_q;
  logic [CW-1:0]     cmp_q;
  logic [CW-1:0]     diff;
  logic [LOST_W-1:0] lost_q;
  logic              fire_q;
  logic              due;

  // due when timestamp is at or past the compare point (wrap-safe)
  assign diff = now_i - cmp_q;
  assign due  = ~diff[CW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_OFF;
      cmp_q  <= '0;
      lost_q <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      case (st_q)
        S_OFF: begin
          if (arm_i) begin
            cmp_q <= now_i + delta_i;
            st_q  <= S_RUN;
          end
        end
        S_RUN: begin
          if (!arm_i) st_q <= S_OFF;
          else if (due) begin
            cmp_q  <= cmp_q + delta_i;
            lost_q <= '0;
            st_q   <= S_CATCH;
          end
        end
        S_CATCH: begin
          if (!arm_i) st_q <= S_OFF;
          else if (due) begin
            cmp_q <= cmp_q + delta_i;
            if (lost_q != '1) lost_q <= lost_q + 1'b1;
          end else begin
            fire_q <= 1'b1;
            st_q   <= S_RUN;
          end
        end
        default: st_q <= S_OFF;
      endcase
    end
  end

  assign fire_o = fire_q;
  assign lost_o = lost_q;

  a_r8_fire_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
  a_r2_no_fire_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !fire_o);
  a_r2_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> st_q == S_OFF);
endmodule

// File: rtl/rtc_emu_detect.sv
module rtc_emu_detect
  import rtc_emu_pkg::*;
#(
  parameter int LIM_W  = 7,
  parameter int LOST_W = 8,
  parameter int MISS_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [LOST_W-1:0] lost_i,
  input  logic              uie_i,
  input  logic              aie_i,
  input  logic              pie_i,
  input  tod_t              tod_i,
  input  tod_t              alm_i,
  input  logic [LIM_W-1:0]  limit_i,
  output logic              irq_o,
  output logic [STW-1:0]    status_o,
  output logic [MISS_W-1:0] missed_o
);
  localparam int SUM_W = ((LIM_W > LOST_W) ? LIM_W : LOST_W) + 2;

  logic [5:0]        prev_q;
  logic              prev_v_q;
  logic [LIM_W-1:0]  pcnt_q;
  logic [MISS_W-1:0] missed_q;
  logic              irq_q;
  logic [STW-1:0]    status_q;

  logic              upd, alm, per;
  logic [SUM_W-1:0]  psum;
  logic [MISS_W:0]   msum;
  logic [STW-1:0]    word;

  always_comb begin
    upd  = uie_i && prev_v_q && (tod_i.sc != prev_q);
    alm  = aie_i && (tod_i == alm_i);
    psum = SUM_W'(pcnt_q) + SUM_W'(lost_i) + SUM_W'(1);
    per  = pie_i && (psum >= SUM_W'(limit_i));
    msum = {1'b0, missed_q} + (MISS_W+1)'(lost_i);
    word = '0;
    word[FLAG_UF]   = upd;
    word[FLAG_AF]   = alm;
    word[FLAG_PF]   = per;
    word[FLAG_PEND] = 1'b1;
    word[STW-1:CNT_LSB] = (STW-CNT_LSB)'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      prev_v_q <= 1'b0;
      pcnt_q   <= '0;
      missed_q <= '0;
      irq_q    <= 1'b0;
      status_q <= '0;
    end else begin
      irq_q    <= 1'b0;
      status_q <= '0;
      // disabled update source forgets its seconds so re-enable only records
      if (!uie_i) prev_v_q <= 1'b0;
      if (!pie_i) pcnt_q <= '0;
      if (fire_i) begin
        missed_q <= msum[MISS_W] ? '1 : msum[MISS_W-1:0];
        if (uie_i) begin
          prev_q   <= tod_i.sc;
          prev_v_q <= 1'b1;
        end
        if (pie_i) pcnt_q <= per ? '0 : psum[LIM_W-1:0];
        if (upd || alm || per) begin
          irq_q    <= 1'b1;
          status_q <= word;
        end
      end
    end
  end

  assign irq_o    = irq_q;
  assign status_o = status_q;
  assign missed_o = missed_q;

  a_r8_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r8_irq_after_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(fire_i));
  a_r4_uf_needs_uie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[FLAG_UF] |-> $past(uie_i));
  a_r9_missed_mono: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> missed_o >= $past(missed_o));
endmodule

// File: rtl/rtc_emu.sv
module rtc_emu
  import rtc_emu_pkg::*;
#(
  parameter int CW     = 32,
  parameter int LIM_W  = 7,
  parameter int LOST_W = 8,
  parameter int MISS_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     now_i,
  input  logic [CW-1:0]     base_delta_i,
  input  logic [CW-1:0]     fast_delta_i,
  input  logic              uie_i,
  input  logic              aie_i,
  input  logic              pie_i,
  input  logic [5:0]        sec_i,
  input  logic [5:0]        min_i,
  input  logic [4:0]        hr_i,
  input  logic [5:0]        alm_sec_i,
  input  logic [5:0]        alm_min_i,
  input  logic [4:0]        alm_hr_i,
  input  logic [LIM_W-1:0]  limit_i,
  output logic              irq_o,
  output logic [15:0]       status_o,
  output logic [MISS_W-1:0] missed_o
);
  logic              arm;
  logic              fast_sel;
  logic [CW-1:0]     delta;
  logic              fire;
  logic [LOST_W-1:0] lost;
  tod_t              tod, alm;

  assign arm      = uie_i | aie_i | pie_i;
  assign fast_sel = pie_i && (limit_i == '0);
  assign delta    = fast_sel ? fast_delta_i : base_delta_i;
  assign tod      = '{hr: hr_i, mn: min_i, sc: sec_i};
  assign alm      = '{hr: alm_hr_i, mn: alm_min_i, sc: alm_sec_i};

  rtc_emu_sched #(.CW(CW), .LOST_W(LOST_W)) u_sched (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm),
    .now_i   (now_i),
    .delta_i (delta),
    .fire_o  (fire),
    .lost_o  (lost)
  );

  rtc_emu_detect #(.LIM_W(LIM_W), .LOST_W(LOST_W), .MISS_W(MISS_W)) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .lost_i   (lost),
    .uie_i    (uie_i),
    .aie_i    (aie_i),
    .pie_i    (pie_i),
    .tod_i    (tod),
    .alm_i    (alm),
    .limit_i  (limit_i),
    .irq_o    (irq_o),
    .status_o (status_o),
    .missed_o (missed_o)
  );
endmodule

// File: tb/sim_rtc_emu.sv
module sim_rtc_emu;
  localparam logic [15:0] W_UF = 16'h0190;
  localparam logic [15:0] W_AF = 16'h01A0;
  localparam logic [15:0] W_PF = 16'h01C0;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [31:0] now_v = '0;
  logic [31:0] base_d, fast_d;
  logic        uie, aie, pie;
  logic [5:0]  sec, mn, asec, amn;
  logic [4:0]  hr, ahr;
  logic [6:0]  limit;
  logic        irq;
  logic [15:0] status;
  logic [15:0] missed;

  rtc_emu u0 (
    .clk_i(clk), .rst_ni(rst_n), .now_i(now_v),
    .base_delta_i(base_d), .fast_delta_i(fast_d),
    .uie_i(uie), .aie_i(aie), .pie_i(pie),
    .sec_i(sec), .min_i(mn), .hr_i(hr),
    .alm_sec_i(asec), .alm_min_i(amn), .alm_hr_i(ahr),
    .limit_i(limit), .irq_o(irq), .status_o(status), .missed_o(missed)
  );

  int total = 0, bad = 0;
  int cyc = 0, n_irq = 0, last_t = 0, gap_t = 0;
  int jump_id = 0, seen_id = 0, jump_amt = 0;
  bit done = 0;
  logic [15:0] exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (jump_id != seen_id) begin
      now_v = now_v + 32'(jump_amt);
      seen_id = jump_id;
    end
    now_v = now_v + 32'd1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected word on each strobe
  always @(negedge clk) begin
    if (rst_n && irq) begin
      gap_t = cyc - last_t;
      last_t = cyc;
      n_irq++;
      if (exp_q.size() == 0) check(1'b0, "R2/R4/R5 unexpected irq", int'(status), 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(status == e, "R8 status word", int'(status), int'(e));
      end
    end else if (rst_n) begin
      if (status != 16'h0) check(1'b0, "R8 status idle", int'(status), 0);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irqs(input int n, input int tmo, input string req);
    int target = n_irq + n;
    int t = 0;
    while (n_irq < target && t < tmo) begin
      @(negedge clk);
      t++;
    end
    check(n_irq >= target, req, n_irq, target);
  endtask

  task automatic expect_none(input int n, input string req);
    int k0 = n_irq;
    idle(n);
    check(n_irq == k0, req, n_irq, k0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; base_d = 32'd20; fast_d = 32'd8;
    uie = 0; aie = 0; pie = 0; limit = 0;
    sec = 0; mn = 0; hr = 0; asec = 0; amn = 0; ahr = 0;
    idle(3);
    check(irq == 0, "R1 irq", int'(irq), 0);
    check(status == 0, "R1 status", int'(status), 0);
    check(missed == 0, "R1 missed", int'(missed), 0);
    rst_n = 1;

    // R2: nothing enabled, time moves
    for (int i = 0; i < 10; i++) begin sec = 6'(i); idle(20); end
    check(n_irq == 0, "R2 disarmed", n_irq, 0);

    // R3 / R4 update source
    sec = 5; uie = 1;
    expect_none(80, "R3 first poll records only");
    sec = 6; exp_q.push_back(W_UF);
    wait_irqs(1, 60, "R4 seconds change");
    expect_none(80, "R4 no change no flag");
    uie = 0; idle(5); sec = 9; uie = 1;
    expect_none(80, "R3 re-enable records only");
    sec = 10; exp_q.push_back(W_UF);
    wait_irqs(1, 60, "R4 second change after re-enable");
    uie = 0; idle(5);

    // R5 alarm
    ahr = 1; amn = 2; asec = 3;
    hr = 1; mn = 2; sec = 4; aie = 1;
    expect_none(80, "R5 seconds mismatch");
    mn = 7; sec = 3;
    expect_none(80, "R5 minutes mismatch");
    mn = 2;
    repeat (3) exp_q.push_back(W_AF);
    wait_irqs(3, 100, "R5 full match");
    hr = 2;
    expect_none(80, "R5 hours mismatch");
    aie = 0; idle(5);

    // R6 slow periodic
    limit = 4; pie = 1;
    repeat (3) exp_q.push_back(W_PF);
    wait_irqs(1, 120, "R6 first periodic");
    wait_irqs(1, 100, "R6 second periodic");
    check(gap_t == 80, "R6 spacing", gap_t, 80);
    wait_irqs(1, 100, "R6 third periodic");
    check(gap_t == 80, "R6 spacing", gap_t, 80);
    pie = 0; idle(30);

    // R7 fast periodic
    limit = 0; pie = 1;
    repeat (4) exp_q.push_back(W_PF);
    wait_irqs(4, 100, "R7 every poll flagged");
    check(gap_t == 8, "R7 fast spacing", gap_t, 8);
    pie = 0; idle(30);
    check(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);

    // R9 catch-up
    limit = 8; pie = 1;
    exp_q.push_back(W_PF);
    wait_irqs(1, 250, "R9 periodic before jump");
    begin
      int m0 = int'(missed);
      jump_amt = 100; jump_id++;
      exp_q.push_back(W_PF);
      wait_irqs(1, 100, "R9 early periodic after lost polls");
      check(gap_t <= 70, "R9 lost polls fed to divider", gap_t, 70);
      check(int'(missed) == m0 + 4, "R9 missed total", int'(missed), m0 + 4);
    end
    pie = 0; idle(30);
    check(exp_q.size() == 0, "R8 all expected seen", exp_q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule